// File: doc/BRIEF.md
# Card-Slot Status and Insertion Interrupt Register Block

This block is a small set of board-control registers that sits beside a removable storage card slot. It watches two level inputs from the slot: a write-protect switch and a card-present detect. It turns them into one status word that software can read. A card insertion is held as a sticky flag that raises an interrupt line. Software reads the status word, services the insertion, then clears the flag by writing a one to its bit position. The write-protect bit needs no clearing, because it always shows the current switch level.

Beside the status word, the block answers with two fixed identification and decode words and a zero word. Any other offset in its small word-addressed window reads zero and raises a one-cycle error flag. Read data and the error flag are registered, so they appear in the cycle after the access.

Top module: `card_slot_regs`

## Requirements
- R1: A read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled high. Word 0 reads 0x41034003, word 1 reads 0x00000000 and word 3 reads 0x00000011. In any cycle that follows no read, `bus_rdata` is zero.
- R2: Bit 0 of the status word at word 2 shows the level of `wp_in` sampled on the previous clock edge. No write changes it.
- R3: Bit 3 of the status word is set on any clock edge where `card_in` is high. It stays set after `card_in` falls.
- R4: A write to word 2 clears status bit 3 when write-data bit 3 is one. It leaves bit 3 alone when write-data bit 3 is zero. Bit 0 is unaffected either way.
- R5: `card_irq` is high exactly when status bit 3 is set.
- R6: If `card_in` is high on the same edge as a clearing write to word 2, bit 3 remains set.
- R7: Writes to words 0, 1 and 3 are accepted without error and change no state.
- R8: A synchronous active-low reset clears the status word, `card_irq`, `bus_rdata` and `bus_err`.
- R9: An access (read or write) to any word from 4 upward pulses `bus_err` high in the following cycle. Such a read returns zero, and such a write changes no state. Accesses to words 0 to 3 leave `bus_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (4) | Word offset of the access |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_err | output | 1 | Registered error pulse for undefined offsets |
| wp_in | input | 1 | Write-protect switch level from the slot |
| card_in | input | 1 | Card-present detect level from the slot |
| card_irq | output | 1 | Card-insertion interrupt |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. Read data and the error pulse appear one edge after the access. The write-protect bit lags `wp_in` by one edge. The sticky flag and `card_irq` change on the edge where `card_in` or a clearing write is sampled. The bench drives each stimulus on the falling edge and samples a quarter period after the next rising edge. A reference model predicts the read value from its state before that edge, and predicts the interrupt from its state after that edge. This keeps each comparison aligned to the single register stage on every path.

// File: rtl/card_slot_pkg.sv
// Package: shared selector type for the card-slot register block.
// Assumes word-granular addressing; the decoder maps offsets onto these codes.
package card_slot_pkg;

    typedef enum logic [2:0] {
        SEL_IDENT  = 3'd0,
        SEL_ZERO   = 3'd1,
        SEL_STATUS = 3'd2,
        SEL_DECODE = 3'd3,
        SEL_NONE   = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/card_slot_decode.sv
// Module: card_slot_decode
// Turns a word offset into a register selector and flags a clearing write
// aimed at the status word. Assumes one access per cycle; purely combinational.
module card_slot_decode
    import card_slot_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int IDENT_WORD  = 0,
    parameter int ZERO_WORD   = 1,
    parameter int STATUS_WORD = 2,
    parameter int DECODE_WORD = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output reg_sel_e          sel_o,
    output logic              status_wr_o
);

    localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(IDENT_WORD);
    localparam logic [ADDR_W-1:0] A_ZERO   = ADDR_W'(ZERO_WORD);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_WORD);
    localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(DECODE_WORD);

    // Map the offset to one of the defined words, else to "none".
    always_comb begin
        unique case (addr_i)
            A_IDENT:  sel_o = SEL_IDENT;
            A_ZERO:   sel_o = SEL_ZERO;
            A_STATUS: sel_o = SEL_STATUS;
            A_DECODE: sel_o = SEL_DECODE;
            default:  sel_o = SEL_NONE;
        endcase
    end

    // A write that lands on the status word is a candidate clear.
    assign status_wr_o = wr_i && (sel_o == SEL_STATUS);

endmodule

// File: rtl/card_slot_status.sv
// Module: card_slot_status
// Holds the status word: a level-following bit for write protect and a
// sticky, write-one-to-clear bit for card insertion. Set wins over clear.
// Assumes WP_BIT and CARD_BIT are distinct and below DATA_W.
module card_slot_status #(
    parameter int DATA_W   = 32,
    parameter int WP_BIT   = 0,
    parameter int CARD_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_in,
    input  logic              card_in,
    input  logic              clr_wr_i,
    input  logic [DATA_W-1:0] clr_data_i,
    output logic [DATA_W-1:0] status_o,
    output logic              card_flag_o
);

    localparam logic [DATA_W-1:0] LEVEL_MASK  = DATA_W'(1) << WP_BIT;
    localparam logic [DATA_W-1:0] STICKY_MASK = DATA_W'(1) << CARD_BIT;

    logic [DATA_W-1:0] level_q;
    logic [DATA_W-1:0] sticky_q;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] level_vec;

    // Place each slot input at its bit, one bit per position.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bits
        if (b == CARD_BIT) begin : g_card
            assign set_vec[b]   = card_in;
            assign level_vec[b] = 1'b0;
        end else if (b == WP_BIT) begin : g_wp
            assign set_vec[b]   = 1'b0;
            assign level_vec[b] = wp_in;
        end else begin : g_rsvd
            assign set_vec[b]   = 1'b0;
            assign level_vec[b] = 1'b0;
        end
    end

    // Only a write addressed to this word may clear anything.
    assign clr_vec = clr_wr_i ? clr_data_i : '0;

    // Sample the level inputs every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_vec & LEVEL_MASK;
    end

    // Sticky bits: clear where written one, then set where active (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= ((sticky_q & ~clr_vec) | set_vec) & STICKY_MASK;
    end

    assign status_o    = level_q | sticky_q;
    assign card_flag_o = sticky_q[CARD_BIT];

    // R2: the protect bit is last cycle's input level.
    p_wp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_o[WP_BIT] == $past(wp_in)));

    // R3: an active detect sets the flag on that edge.
    p_card_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        card_in |=> card_flag_o);

    // R3: without a clearing write the flag holds.
    p_card_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (card_flag_o && !(clr_wr_i && clr_data_i[CARD_BIT])) |=> card_flag_o);

    // R4: a clearing write with no detect drops the flag.
    p_card_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_data_i[CARD_BIT] && !card_in) |=> !card_flag_o);

    // R6: detect and clear together leave the flag set.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && card_in) |=> card_flag_o);

endmodule

// File: rtl/card_slot_rdport.sv
// Module: card_slot_rdport
// Registers the read data and the error pulse for one access per cycle.
// Assumes the selector is decoded from the same cycle's offset.
module card_slot_rdport
    import card_slot_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter logic [DATA_W-1:0] IDENT_VAL  = 32'h4103_4003,
    parameter logic [DATA_W-1:0] DECODE_VAL = 32'h0000_0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    logic [DATA_W-1:0] mux_val;

    // Choose the word for the selected offset; undefined ones give zero.
    always_comb begin
        unique case (sel_i)
            SEL_IDENT:  mux_val = IDENT_VAL;
            SEL_STATUS: mux_val = status_i;
            SEL_DECODE: mux_val = DECODE_VAL;
            default:    mux_val = '0;
        endcase
    end

    // Capture read data, zero when no read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= rd_i ? mux_val : '0;
    end

    // Raise a one-cycle error for any access outside the defined words.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= (rd_i || wr_i) && (sel_i == SEL_NONE);
    end

endmodule

// File: rtl/card_slot_regs.sv
// Module: card_slot_regs (top)
// Board-control register window for a card slot: fixed identity and decode
// words, a status word with write protect and sticky insertion, and an
// insertion interrupt. Assumes one read or write per cycle, word offsets.
module card_slot_regs
    import card_slot_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 32,
    parameter int                WP_BIT     = 0,
    parameter int                CARD_BIT   = 3,
    parameter logic [DATA_W-1:0] IDENT_VAL  = 32'h4103_4003,
    parameter logic [DATA_W-1:0] DECODE_VAL = 32'h0000_0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              wp_in,
    input  logic              card_in,
    output logic              card_irq
);

    localparam int LAST_WORD = 3;

    reg_sel_e          sel;
    logic              status_wr;
    logic [DATA_W-1:0] status;
    logic              card_flag;

    card_slot_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr_i      (bus_addr),
        .wr_i        (bus_wr),
        .sel_o       (sel),
        .status_wr_o (status_wr)
    );

    card_slot_status #(
        .DATA_W   (DATA_W),
        .WP_BIT   (WP_BIT),
        .CARD_BIT (CARD_BIT)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wp_in       (wp_in),
        .card_in     (card_in),
        .clr_wr_i    (status_wr),
        .clr_data_i  (bus_wdata),
        .status_o    (status),
        .card_flag_o (card_flag)
    );

    card_slot_rdport #(
        .DATA_W     (DATA_W),
        .IDENT_VAL  (IDENT_VAL),
        .DECODE_VAL (DECODE_VAL)
    ) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (bus_rd),
        .wr_i     (bus_wr),
        .sel_i    (sel),
        .status_i (status),
        .rdata_o  (bus_rdata),
        .err_o    (bus_err)
    );

    // Interrupt is the insertion flag itself.
    assign card_irq = card_flag;

    // R1: the identity word appears one cycle after its read.
    p_ident_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == '0) |=> (bus_rdata == IDENT_VAL));

    // R1: no read means zero data next cycle.
    p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R5: a rising detect raises the interrupt next edge.
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_in |=> card_irq);

    // R9: out-of-window access gives an error and zero data.
    p_undef_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && (bus_addr > ADDR_W'(LAST_WORD))) |=> (bus_err && bus_rdata == '0));

    // R9: in-window accesses never error.
    p_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr <= ADDR_W'(LAST_WORD)) |=> !bus_err);

endmodule

// File: tb/card_slot_regs_tb.sv
module card_slot_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        wp_in = 1'b0;
    logic        card_in = 1'b0;
    logic        card_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic m_wp   = 1'b0;
    logic m_card = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_slot_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .wp_in(wp_in), .card_in(card_in), .card_irq(card_irq)
    );

    function automatic logic [31:0] exp_word(input logic [3:0] a, input logic wp, input logic cd);
        case (a)
            4'd0:    return 32'h4103_4003;
            4'd2:    return {28'd0, cd, 2'b00, wp};
            4'd3:    return 32'h0000_0011;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        if (a > 4'd3)       return "R9";
        else if (a == 4'd2) return "R2";
        else                return "R1";
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
    endtask

    // One bus cycle: drive, predict, advance one edge, compare.
    task automatic step(input logic rd, input logic wr, input logic [3:0] a,
                        input logic [31:0] wd, input logic wp, input logic cd, input string req);
        logic [31:0] e_rdata;
        logic        e_err;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        wp_in = wp; card_in = cd;
        e_rdata = rd ? exp_word(a, m_wp, m_card) : 32'h0;
        e_err   = (rd || wr) && (a > 4'd3);
        m_wp    = wp;
        if (cd)                             m_card = 1'b1;
        else if (wr && a == 4'd2 && wd[3])  m_card = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(req, "rdata", bus_rdata, e_rdata);
        check(req, "err", {31'd0, bus_err}, {31'd0, e_err});
        check("R5", "irq", {31'd0, card_irq}, {31'd0, m_card});
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20250611));
        // R8: reset
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check("R8", "rdata in reset", bus_rdata, 32'h0);
        check("R8", "err in reset", {31'd0, bus_err}, 32'h0);
        check("R8", "irq in reset", {31'd0, card_irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 4'd2, 0, 0, 0, "R8");

        // R1: fixed words
        step(1, 0, 4'd0, 0, 0, 0, "R1");
        step(1, 0, 4'd1, 0, 0, 0, "R1");
        step(1, 0, 4'd3, 0, 0, 0, "R1");
        step(0, 0, 4'd0, 0, 0, 0, "R1");

        // R2: protect level follows
        step(0, 0, 4'd0, 0, 1, 0, "R2");
        step(1, 0, 4'd2, 0, 1, 0, "R2");
        step(1, 0, 4'd2, 0, 0, 0, "R2");
        step(1, 0, 4'd2, 0, 1, 0, "R2");

        // R3: pulse then hold
        step(0, 0, 4'd0, 0, 1, 1, "R3");
        step(1, 0, 4'd2, 0, 1, 0, "R3");
        step(1, 0, 4'd2, 0, 1, 0, "R3");

        // R4: no clear without bit 3, then clear
        step(0, 1, 4'd2, 32'hFFFF_FFF7, 1, 0, "R4");
        step(1, 0, 4'd2, 0, 1, 0, "R4");
        step(0, 1, 4'd2, 32'h0000_0008, 1, 0, "R4");
        step(1, 0, 4'd2, 0, 1, 0, "R4");

        // R6: set beats clear
        step(0, 1, 4'd2, 32'hFFFF_FFFF, 1, 1, "R6");
        step(1, 0, 4'd2, 0, 1, 0, "R6");

        // R7: writes elsewhere do nothing
        step(0, 1, 4'd0, 32'hFFFF_FFFF, 1, 0, "R7");
        step(0, 1, 4'd1, 32'hFFFF_FFFF, 1, 0, "R7");
        step(0, 1, 4'd3, 32'hFFFF_FFFF, 1, 0, "R7");
        step(1, 0, 4'd2, 0, 1, 0, "R7");

        // R9: undefined offsets
        step(1, 0, 4'd7, 0, 1, 0, "R9");
        step(1, 0, 4'd15, 0, 1, 0, "R9");
        step(0, 1, 4'd9, 32'hFFFF_FFFF, 1, 0, "R9");
        step(1, 0, 4'd2, 0, 1, 0, "R9");
        step(0, 1, 4'd2, 32'h8, 0, 0, "R4");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] a;
            logic rd, wr;
            int k;
            k  = $urandom_range(0, 9);
            rd = (k < 5);
            wr = (k >= 5 && k < 8);
            a  = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3));
            step(rd, wr, a, (($urandom_range(0, 1) == 0) ? 32'h8 : $urandom),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0), tag_for(a));
        end

        summary();
        $finish;
    end

endmodule